// File: doc/BRIEF.md
# Lock-Qualified Reset Synchronizer

This block produces the active-high reset for one clock domain from a raw asynchronous reset and the lock indication of the clock generator that feeds that domain. Reset is applied to the domain as soon as either the raw reset rises or lock falls, with no clock edge needed. Release happens only on a rising clock edge, after a short chain of flops has filled with ones. Because every downstream flop then leaves reset on the same edge, a one-hot state machine cannot start with two hot bits or with none. Recovery timing at the downstream flops can be checked by static timing in the same way as a setup check.

The chain is cleared whenever raw reset is high or lock is low. While both conditions are clear, it fills by one bit per rising edge. The output reset is the inverse of the last chain bit. With the default depth of two, release comes on the second rising edge after both conditions have cleared.

Top module: `lockRstSync`

## Requirements
- R1: A rising raw reset (`rawRstIn` = 1) drives `rstOut` to 1 in the same time step, between clock edges, without waiting for a clock edge.
- R2: A falling lock (`lockIn` = 0) drives `rstOut` to 1 in the same time step, between clock edges, in the same way as the raw reset.
- R3: `rstOut` goes from 1 to 0 only at a rising edge of `clk`, never between edges.
- R4: Once `rawRstIn` = 0 and `lockIn` = 1, `rstOut` is still 1 after the first rising edge and is 0 after the second rising edge (STAGES = 2).
- R5: While `lockIn` = 0, `rstOut` stays 1 for any number of clock edges, whatever the level of `rawRstIn`.
- R6: While `rawRstIn` = 1, `rstOut` stays 1 for any number of clock edges, even with `lockIn` = 1.
- R7: After release, `rstOut` stays 0 for as long as `rawRstIn` = 0 and `lockIn` = 1.
- R8: A reset pulse or a loss of lock that happens during the release sequence, or between two edges with nothing else changing, restarts the full two-edge count from zero.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the domain being reset |
| rawRstIn | input | 1 | Raw asynchronous reset, active high |
| lockIn | input | 1 | Lock indication from the clock generator, high when locked |
| rstOut | output | 1 | Domain reset, active high; asserts asynchronously, releases on a rising edge |

## Verification
Two functions of the block can fall into the same clock period. One is the asynchronous re-assertion caused by raw reset or by loss of lock. The other is the synchronous release count carried by the chain. The bench provokes the overlap in two ways. It pulses raw reset, or drops lock, between two edges after the chain has already taken one bit. It also drops both conditions at the same moment. It then samples the output one time unit after the stimulus, to see the asynchronous assertion. It compares the output on every falling clock edge with a reference that counts the clean edges since the last disturbance. A correct design must go back to a full two-edge count and must never release early.

// File: rtl/lockRstSyncPkg.sv
package lockRstSyncPkg;

  // Strobes passed from the release control to the flop chain.
  typedef struct packed {
    logic holdoff;   // clear the chain at once, no clock needed
    logic shiftIn;   // value entered into the first stage each edge
  } rstCtrl_t;

endpackage

// File: rtl/rstSyncCtrl.sv
module rstSyncCtrl
  import lockRstSyncPkg::*;
(
  input  logic     rawRstIn,
  input  logic     lockIn,
  output rstCtrl_t strobes
);

  logic notLocked;

  assign notLocked = ~lockIn;

  always_comb begin
    strobes.holdoff = rawRstIn | notLocked;
    strobes.shiftIn = ~(rawRstIn | notLocked);
  end

endmodule

// File: rtl/rstSyncChain.sv
module rstSyncChain
  import lockRstSyncPkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  rstCtrl_t strobes,
  output logic     releaseOk
);

  localparam int LAST = STAGES - 1;

  logic              holdoff;
  logic [STAGES-1:0] chain;

  assign holdoff = strobes.holdoff;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic dIn;
    if (i == 0) begin : g_head
      assign dIn = strobes.shiftIn;
    end else begin : g_tail
      assign dIn = chain[i-1];
    end
    always_ff @(posedge clk or posedge holdoff) begin
      if (holdoff) chain[i] <= 1'b0;
      else         chain[i] <= dIn;
    end
  end

  assign releaseOk = chain[LAST];

endmodule

// File: rtl/lockRstSync.sv
module lockRstSync
  import lockRstSyncPkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rawRstIn,
  input  logic lockIn,
  output logic rstOut
);

  rstCtrl_t strobes;
  logic     releaseOk;

  rstSyncCtrl ctrl_i (
    .rawRstIn (rawRstIn),
    .lockIn   (lockIn),
    .strobes  (strobes)
  );

  rstSyncChain #(.STAGES(STAGES)) chain_i (
    .clk       (clk),
    .strobes   (strobes),
    .releaseOk (releaseOk)
  );

  assign rstOut = ~releaseOk;

endmodule

// File: rtl/lockRstSyncChk.sv
module lockRstSyncChk #(
  parameter int STAGES = 2
) (
  input logic clk,
  input logic rawRstIn,
  input logic lockIn,
  input logic rstOut
);

  localparam int CW = $clog2(STAGES + 1);

  logic          holdoff;
  logic          seenEdge;
  logic [CW-1:0] cleanEdges;

  assign holdoff = rawRstIn | ~lockIn;

  initial seenEdge = 1'b0;
  always @(posedge clk) seenEdge <= 1'b1;

  // Independent count of clean edges since the last disturbance.
  always_ff @(posedge clk or posedge holdoff) begin
    if (holdoff)                         cleanEdges <= '0;
    else if (cleanEdges != CW'(STAGES))  cleanEdges <= cleanEdges + 1'b1;
  end

  assert_raw_holds_R1: assert property (@(negedge clk) disable iff (!seenEdge)
    rawRstIn |-> rstOut) else $error("R1/R6 raw reset not reflected");

  assert_lock_holds_R2: assert property (@(negedge clk) disable iff (!seenEdge)
    !lockIn |-> rstOut) else $error("R2/R5 lock loss not reflected");

  assert_release_late_R4: assert property (@(posedge clk) disable iff (holdoff || !seenEdge)
    (cleanEdges < CW'(STAGES)) |-> rstOut) else $error("R4/R8 early release");

  assert_stays_low_R7: assert property (@(posedge clk) disable iff (holdoff || !seenEdge)
    (cleanEdges == CW'(STAGES)) |-> !rstOut) else $error("R7 reset came back");

  always @(negedge rstOut) begin
    if (seenEdge) begin
      assert_fall_on_edge_R3: assert (clk == 1'b1) else $error("R3 release off edge");
    end
  end

endmodule

bind lockRstSync lockRstSyncChk #(.STAGES(STAGES)) chk_i (.*);

// File: tb/lockRstSync_tb_top.sv
module lockRstSync_tb_top;

  localparam int PERIOD = 10;
  localparam int DEPTH  = 2;

  logic clk = 1'b0;
  logic rawRstIn;
  logic lockIn;
  logic rstOut;

  int checks = 0;
  int errors = 0;
  int cleanCnt = 0;
  int offEdgeFalls = 0;
  bit finished = 1'b0;
  string curReq = "R6";

  lockRstSync #(.STAGES(DEPTH)) dut_i (
    .clk      (clk),
    .rawRstIn (rawRstIn),
    .lockIn   (lockIn),
    .rstOut   (rstOut)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic expected();
    if (rawRstIn || !lockIn) return 1'b1;
    return (cleanCnt < DEPTH);
  endfunction

  // Reference model: count clean rising edges.
  always @(posedge clk) begin
    if (rawRstIn || !lockIn) cleanCnt = 0;
    else if (cleanCnt < DEPTH) cleanCnt = cleanCnt + 1;
  end

  always @(negedge rstOut) begin
    if ($time > 0 && clk !== 1'b1) offEdgeFalls++;
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: rstOut=%b expected=%b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) check(curReq, rstOut, expected());
  end

  task automatic drive(input logic r, input logic l);
    rawRstIn = r;
    lockIn   = l;
    if (r || !l) cleanCnt = 0;
  endtask

  // Move to a point 2 units after the next rising edge.
  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    drive(1'b1, 1'b0);
    edges(3);
    check("R6", rstOut, 1'b1);            // reset state
    curReq = "R6";
    drive(1'b1, 1'b1);                    // locked, raw reset still high
    edges(3);
    check("R6", rstOut, 1'b1);

    curReq = "R4";
    drive(1'b0, 1'b1);
    edges(1);
    check("R4", rstOut, 1'b1);            // one edge: still held
    edges(1);
    check("R4", rstOut, 1'b0);            // second edge: released
    curReq = "R7";
    edges(5);
    check("R7", rstOut, 1'b0);

    // Raw reset pulse between edges
    drive(1'b1, 1'b1);
    #1 check("R1", rstOut, 1'b1);
    drive(1'b0, 1'b1);
    #1 check("R8", rstOut, 1'b1);
    curReq = "R8";
    edges(1);
    check("R8", rstOut, 1'b1);
    edges(1);
    check("R8", rstOut, 1'b0);

    // Lock loss between edges, held low for several edges
    curReq = "R5";
    drive(1'b0, 1'b0);
    #1 check("R2", rstOut, 1'b1);
    edges(4);
    check("R5", rstOut, 1'b1);
    drive(1'b1, 1'b0);
    edges(2);
    drive(1'b0, 1'b0);                    // raw clear, still unlocked
    edges(3);
    check("R5", rstOut, 1'b1);
    curReq = "R4";
    drive(1'b0, 1'b1);
    edges(1);
    check("R4", rstOut, 1'b1);
    edges(1);
    check("R4", rstOut, 1'b0);

    // Disturbance in the middle of release
    curReq = "R8";
    drive(1'b1, 1'b1);
    edges(1);
    drive(1'b0, 1'b1);
    edges(1);                             // chain has one bit
    drive(1'b0, 1'b0);
    #1 check("R2", rstOut, 1'b1);
    drive(1'b0, 1'b1);
    edges(1);
    check("R8", rstOut, 1'b1);
    edges(1);
    check("R8", rstOut, 1'b0);

    // Both conditions clear together after both being set
    drive(1'b1, 1'b0);
    #1 check("R1", rstOut, 1'b1);
    edges(2);
    drive(1'b0, 1'b1);
    edges(1);
    check("R4", rstOut, 1'b1);
    edges(1);
    check("R4", rstOut, 1'b0);
    curReq = "R7";
    edges(4);

    checks++;
    if (offEdgeFalls != 0) begin
      errors++;
      $display("FAIL R3: off-edge releases=%0d expected=0", offEdgeFalls);
    end
    finish();
  end

  initial begin
    #(PERIOD * 5000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, actual=timeout expected=done");
      finish();
    end
  end

endmodule